// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block produces the raster timing for a parallel RGB panel in the pixel clock domain. It drives horizontal and vertical sync, a data-enable strobe, the current pixel coordinates, a one-cycle start-of-frame pulse and a one-cycle end-of-active-frame event.

The timing comes from four packed 32-bit configuration words, each holding two 16-bit fields, and from two polarity inputs. Each scan line runs in this order: active pixels, front porch, sync pulse, back porch. Each frame runs through lines in the same order.

Configuration is copied into shadow registers only while the generator is stopped or on the last pixel of a frame. A new setting therefore always takes effect on a whole frame. A run input starts and stops frame generation.

Top module: `lcd_timing_gen`

## Requirements
- R1: A line lasts (A+1)+(F+1)+(S+1)+(B+1) pixel clocks, where A = `cfgActive[15:0]`, F = `cfgHPorch[15:0]`, B = `cfgHPorch[31:16]` and S = `cfgSync[15:0]`. The horizontal sync is active for S+1 clocks, starting (A+1)+(F+1) clocks after the line's first pixel.
- R2: A frame lasts (A+1)+(F+1)+(S+1)+VB lines, where A = `cfgActive[31:16]`, F = `cfgVPorch[15:0]`, S = `cfgSync[31:16]` and VB = `cfgVPorch[31:16]` taken with no offset. The vertical sync is active for S+1 whole lines, starting after (A+1)+(F+1) lines.
- R3: With a vertical back porch of zero, the first line of the next frame follows directly on the last sync line.
- R4: When `hsLow` is 1 the horizontal sync is driven 0 while active and 1 while inactive; when it is 0 the levels are the reverse. `vsLow` does the same for the vertical sync.
- R5: `de` is 1 exactly when the horizontal position is below the active width and the line is below the active height, so each frame holds (width × height) enabled clocks.
- R6: `frameStart` pulses for one clock at pixel (0,0) of each frame.
- R7: `vblankEvt` pulses for one clock on the last active pixel of the last active line.
- R8: A configuration change made in the middle of a frame does not alter that frame; it takes effect from the next frame.
- R9: While `run` is low, `de`, `frameStart` and `vblankEvt` are 0, both syncs sit at their inactive levels, and `pixX` and `pixY` read 0. Outputs go inactive one clock after `run` falls.
- R10: One clock after `run` rises, the generator is at pixel (0,0) with `frameStart` high and the configuration present at that edge in use.
- R11: `pixX` and `pixY` give the horizontal and vertical position inside the frame while running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Start (1) or stop (0) frame generation |
| cfgSync | input | 32 | [15:0] hsync width-1, [31:16] vsync width-1 |
| cfgVPorch | input | 32 | [15:0] vertical front porch-1, [31:16] vertical back porch (no offset) |
| cfgHPorch | input | 32 | [15:0] horizontal front porch-1, [31:16] horizontal back porch-1 |
| cfgActive | input | 32 | [15:0] active width-1, [31:16] active height-1 |
| hsLow | input | 1 | 1 makes hsync active-low |
| vsLow | input | 1 | 1 makes vsync active-low |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pixX | output | 19 | Horizontal position |
| pixY | output | 19 | Vertical position |
| frameStart | output | 1 | One-clock start-of-frame pulse |
| vblankEvt | output | 1 | One-clock end-of-active-frame pulse |

## Verification
The bench measures whole frames under three geometries and compares their lengths, sync positions and widths, and enable counts with values derived from the fields.

A decoder that applied the minus-one offset to the vertical back porch would make every frame one line too long. The zero-back-porch case would then fail to wrap straight into the next frame.

A configuration change is made mid-frame. A design that reloads its shadow early would shorten that frame.

The stop and restart cases catch outputs that keep their active levels or coordinates that fail to return to the origin. Inverted polarity settings catch a sync that ignores its polarity bit while idle.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic step;    // advance the raster counters
    logic clear;   // hold the counters at the origin
    logic reload;  // copy configuration into the shadow registers
  } lcdtStrb_t;

  // position flags from datapath back to control
  typedef struct packed {
    logic lineLast;
    logic frameLast;
  } lcdtFlag_t;
endpackage

// File: rtl/lcdt_ctrl.sv
module lcdt_ctrl
  import lcdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  lcdtFlag_t flag,
  output lcdtStrb_t strb,
  output logic      running
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) running <= 1'b0;
    else        running <= run;
  end

  always_comb begin
    strb.step   = running;
    strb.clear  = !running;
    strb.reload = !running || flag.frameLast;
  end

  // R8: a reload is only ever requested at a frame boundary or while idle
  p_reload_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !flag.frameLast) |-> !strb.reload);
endmodule

// File: rtl/lcdt_datapath.sv
module lcdt_datapath
  import lcdt_pkg::*;
#(
  parameter int FIELD_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  lcdtStrb_t            strb,
  input  logic                 running,
  input  logic [2*FIELD_W-1:0] cfgSync,
  input  logic [2*FIELD_W-1:0] cfgVPorch,
  input  logic [2*FIELD_W-1:0] cfgHPorch,
  input  logic [2*FIELD_W-1:0] cfgActive,
  input  logic                 hsLow,
  input  logic                 vsLow,
  output lcdtFlag_t            flag,
  output logic                 hsync,
  output logic                 vsync,
  output logic                 de,
  output logic [FIELD_W+2:0]   pixX,
  output logic [FIELD_W+2:0]   pixY,
  output logic                 frameStart,
  output logic                 vblankEvt
);
  localparam int CNT_W = FIELD_W + 3;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] widen(input logic [FIELD_W-1:0] f);
    return CNT_W'(f);
  endfunction

  // boundaries derived from the incoming words, stored on reload
  logic [CNT_W-1:0] hActN, hSyncBegN, hSyncEndN, hTotN;
  logic [CNT_W-1:0] vActN, vSyncBegN, vSyncEndN, vTotN;

  always_comb begin
    hActN     = widen(cfgActive[FIELD_W-1:0]) + ONE;
    hSyncBegN = hActN + widen(cfgHPorch[FIELD_W-1:0]) + ONE;
    hSyncEndN = hSyncBegN + widen(cfgSync[FIELD_W-1:0]) + ONE;
    hTotN     = hSyncEndN + widen(cfgHPorch[2*FIELD_W-1:FIELD_W]) + ONE;
    vActN     = widen(cfgActive[2*FIELD_W-1:FIELD_W]) + ONE;
    vSyncBegN = vActN + widen(cfgVPorch[FIELD_W-1:0]) + ONE;
    vSyncEndN = vSyncBegN + widen(cfgSync[2*FIELD_W-1:FIELD_W]) + ONE;
    // vertical back porch carries no offset
    vTotN     = vSyncEndN + widen(cfgVPorch[2*FIELD_W-1:FIELD_W]);
  end

  logic [CNT_W-1:0] hAct, hSyncBeg, hSyncEnd, hTot;
  logic [CNT_W-1:0] vAct, vSyncBeg, vSyncEnd, vTot;
  logic             hsLowQ, vsLowQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hAct <= '0; hSyncBeg <= '0; hSyncEnd <= '0; hTot <= '0;
      vAct <= '0; vSyncBeg <= '0; vSyncEnd <= '0; vTot <= '0;
      hsLowQ <= 1'b0; vsLowQ <= 1'b0;
    end else if (strb.reload) begin
      hAct <= hActN; hSyncBeg <= hSyncBegN; hSyncEnd <= hSyncEndN; hTot <= hTotN;
      vAct <= vActN; vSyncBeg <= vSyncBegN; vSyncEnd <= vSyncEndN; vTot <= vTotN;
      hsLowQ <= hsLow; vsLowQ <= vsLow;
    end
  end

  logic [CNT_W-1:0] hCnt, vCnt;

  always_comb begin
    flag.lineLast  = (hCnt == hTot - ONE);
    flag.frameLast = flag.lineLast && (vCnt == vTot - ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (strb.clear) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (strb.step) begin
      if (flag.lineLast) begin
        hCnt <= '0;
        vCnt <= flag.frameLast ? '0 : vCnt + ONE;
      end else begin
        hCnt <= hCnt + ONE;
      end
    end
  end

  logic inH, inV, hsOn, vsOn;
  always_comb begin
    inH  = hCnt < hAct;
    inV  = vCnt < vAct;
    hsOn = (hCnt >= hSyncBeg) && (hCnt < hSyncEnd);
    vsOn = (vCnt >= vSyncBeg) && (vCnt < vSyncEnd);
    de         = running && inH && inV;
    hsync      = (running && hsOn) ^ hsLowQ;
    vsync      = (running && vsOn) ^ vsLowQ;
    pixX       = running ? hCnt : '0;
    pixY       = running ? vCnt : '0;
    frameStart = running && (hCnt == '0) && (vCnt == '0);
    vblankEvt  = running && (hCnt == hAct - ONE) && (vCnt == vAct - ONE);
  end

  p_idle_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clear |=> (hCnt == '0) && (vCnt == '0));
  p_h_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.step && !flag.lineLast) |=> hCnt == $past(hCnt) + ONE);
  p_h_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.step && flag.lineLast) |=> hCnt == '0);
  p_v_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.step && flag.frameLast) |=> vCnt == '0);
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.step && !flag.frameLast) |=> $stable(hTot) && $stable(vTot) && $stable(vAct));
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcdt_pkg::*;
#(
  parameter int FIELD_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [2*FIELD_W-1:0] cfgSync,
  input  logic [2*FIELD_W-1:0] cfgVPorch,
  input  logic [2*FIELD_W-1:0] cfgHPorch,
  input  logic [2*FIELD_W-1:0] cfgActive,
  input  logic                 hsLow,
  input  logic                 vsLow,
  output logic                 hsync,
  output logic                 vsync,
  output logic                 de,
  output logic [FIELD_W+2:0]   pixX,
  output logic [FIELD_W+2:0]   pixY,
  output logic                 frameStart,
  output logic                 vblankEvt
);
  lcdtStrb_t strb;
  lcdtFlag_t flag;
  logic      running;

  lcdt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .run(run), .flag(flag),
    .strb(strb), .running(running)
  );

  lcdt_datapath #(.FIELD_W(FIELD_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .running(running),
    .cfgSync(cfgSync), .cfgVPorch(cfgVPorch), .cfgHPorch(cfgHPorch),
    .cfgActive(cfgActive), .hsLow(hsLow), .vsLow(vsLow),
    .flag(flag), .hsync(hsync), .vsync(vsync), .de(de),
    .pixX(pixX), .pixY(pixY), .frameStart(frameStart), .vblankEvt(vblankEvt)
  );

  // R6: the start-of-frame pulse never lasts two clocks in a row
  p_fs_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |=> !frameStart);
endmodule

// File: tb/sim_lcd_timing_gen.sv
module sim_lcd_timing_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [31:0] cfgSync = '0, cfgVPorch = '0, cfgHPorch = '0, cfgActive = '0;
  logic hsLow = 1'b0, vsLow = 1'b0;
  logic hsync, vsync, de, frameStart, vblankEvt;
  logic [18:0] pixX, pixY;

  always #5 clk = ~clk;

  lcd_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .cfgSync(cfgSync), .cfgVPorch(cfgVPorch),
    .cfgHPorch(cfgHPorch), .cfgActive(cfgActive), .hsLow(hsLow), .vsLow(vsLow),
    .hsync(hsync), .vsync(vsync), .de(de), .pixX(pixX), .pixY(pixY),
    .frameStart(frameStart), .vblankEvt(vblankEvt)
  );

  // stimulus table: stored fields (minus one except VB) and expected frame length
  localparam int NV = 3;
  localparam int TA[NV] = '{3, 7, 0};  // active width-1
  localparam int TF[NV] = '{0, 2, 0};  // h front porch-1
  localparam int TS[NV] = '{1, 0, 0};  // hsync width-1
  localparam int TB[NV] = '{0, 3, 0};  // h back porch-1
  localparam int UA[NV] = '{2, 1, 0};  // active height-1
  localparam int UF[NV] = '{0, 1, 0};  // v front porch-1
  localparam int US[NV] = '{0, 2, 0};  // vsync width-1
  localparam int UB[NV] = '{2, 0, 1};  // v back porch, raw
  localparam bit PH[NV] = '{1'b0, 1'b1, 1'b1};
  localparam bit PV[NV] = '{1'b0, 1'b1, 1'b0};
  localparam int FL[NV] = '{56, 112, 16};

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic loadVec(input int i);
    cfgActive = {16'(UA[i]), 16'(TA[i])};
    cfgHPorch = {16'(TB[i]), 16'(TF[i])};
    cfgVPorch = {16'(UB[i]), 16'(UF[i])};
    cfgSync   = {16'(US[i]), 16'(TS[i])};
    hsLow = PH[i];
    vsLow = PV[i];
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R9)
    chk(!de && !frameStart && !vblankEvt, "R9 reset outputs", int'(de), 0);
    chk(hsync == 1'b0 && vsync == 1'b0, "R9 reset syncs", int'({hsync, vsync}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      int hA, hF, hS, hB, vA, vF, vS, vB, hT, vT;
      int deN, hsN, vsN, fsN, hsFirst, vsFirst, vbIdx, vbN;
      hA = TA[i] + 1; hF = TF[i] + 1; hS = TS[i] + 1; hB = TB[i] + 1;
      vA = UA[i] + 1; vF = UF[i] + 1; vS = US[i] + 1; vB = UB[i];
      hT = hA + hF + hS + hB; vT = vA + vF + vS + vB;
      run = 1'b0;
      loadVec(i);
      repeat (3) @(negedge clk);
      // idle levels follow polarity (R4, R9)
      chk(hsync == PH[i], "R4 idle hsync", int'(hsync), int'(PH[i]));
      chk(vsync == PV[i], "R4 idle vsync", int'(vsync), int'(PV[i]));
      chk(!de && pixX == 0 && pixY == 0, "R9 idle", int'(pixX), 0);
      run = 1'b1;
      deN = 0; hsN = 0; vsN = 0; fsN = 0; hsFirst = -1; vsFirst = -1; vbIdx = -1; vbN = 0;
      for (int k = 0; k < FL[i]; k++) begin
        @(negedge clk);
        if (k == 0) begin
          chk(frameStart && pixX == 0 && pixY == 0, "R10 origin", int'(pixX), 0);
        end
        if (de) deN++;
        if (de != (int'(pixX) < hA && int'(pixY) < vA)) begin
          chk(1'b0, "R5 de region", int'(de), int'(!de));
        end
        if (hsync != PH[i]) begin hsN++; if (hsFirst < 0) hsFirst = k; end
        if (vsync != PV[i]) begin vsN++; if (vsFirst < 0) vsFirst = k; end
        if (frameStart) fsN++;
        if (vblankEvt) begin
          vbN++; vbIdx = k;
          chk(int'(pixX) == hA - 1 && int'(pixY) == vA - 1, "R11 position", int'(pixX), hA - 1);
        end
      end
      chk(hT * vT == FL[i], "R2 table length", hT * vT, FL[i]);
      chk(deN == hA * vA, "R5 de count", deN, hA * vA);
      chk(hsFirst == hA + hF, "R1 hsync start", hsFirst, hA + hF);
      chk(hsN == hS * vT, "R1 hsync width", hsN, hS * vT);
      chk(vsFirst == (vA + vF) * hT, "R2 vsync start", vsFirst, (vA + vF) * hT);
      chk(vsN == vS * hT, "R2 vsync width", vsN, vS * hT);
      chk(fsN == 1, "R6 one start pulse", fsN, 1);
      chk(vbN == 1 && vbIdx == (vA - 1) * hT + hA - 1, "R7 vblank position", vbIdx,
          (vA - 1) * hT + hA - 1);
      @(negedge clk);
      if (vB == 0) chk(frameStart == 1'b1, "R3 wrap after zero back porch", int'(frameStart), 1);
      else         chk(frameStart == 1'b1, "R2 frame wrap", int'(frameStart), 1);
    end

    // R8: mid-frame change must not tear the current frame
    run = 1'b0;
    loadVec(0);
    repeat (3) @(negedge clk);
    run = 1'b1;
    begin
      int fsAt1, fsAt2, deFirst;
      fsAt1 = -1; fsAt2 = -1; deFirst = 0;
      for (int k = 0; k < 80; k++) begin
        @(negedge clk);
        if (k == 10) loadVec(2);
        if (k < 56 && de) deFirst++;
        if (frameStart && k > 0) begin
          if (fsAt1 < 0) fsAt1 = k;
          else if (fsAt2 < 0) fsAt2 = k;
        end
      end
      chk(fsAt1 == 56, "R8 old frame kept", fsAt1, 56);
      chk(deFirst == 12, "R8 old enable count", deFirst, 12);
      chk(fsAt2 == 72, "R8 new frame applied", fsAt2, 72);
    end

    // R9: stopping mid-frame forces inactive outputs one clock later
    run = 1'b0;
    @(negedge clk);
    chk(!de && !frameStart && !vblankEvt, "R9 stop outputs", int'(de), 0);
    chk(hsync == 1'b1 && vsync == 1'b0, "R9 stop syncs", int'({hsync, vsync}), 2);
    chk(pixX == 0 && pixY == 0, "R9 stop position", int'(pixX) + int'(pixY), 0);
    @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    chk(frameStart && de && pixX == 0, "R10 restart at origin", int'(frameStart), 1);
    finishRun();
  end
endmodule